// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a two-wire serial slave (SMBus/I2C style) that holds ten 8-bit configuration registers for a clock-generation core. A host reaches the registers through byte transfers or block transfers. The command byte that follows the write address picks the kind of transfer. Every register bit is driven out on a flat vector to the clock-control logic. A few status positions are not stored; they read back the live values of external pins.

The block samples the serial clock and data lines with the fast system clock. It finds start, repeated-start and stop conditions, matches its 7-bit address 0x69, and acknowledges each accepted byte by pulling SDA low. It keeps an auto-incrementing register pointer. On reads it shifts bytes out most significant bit first. Clock stretching, packet error codes and bus timeouts are not part of the block.

Top module: `smb_cfg_bank`

## Requirements
- R1: After reset the stored registers hold 0x08, 0x07, 0x7F, 0xC7, 0x3F, 0x40, 0x00, 0x00, 0x00, 0x00 for offsets 0 to 9. These values appear on `cfg_o` as byte i at bits 8i+7:8i, with read-only positions shown as 0.
- R2: Only address byte 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69, is acknowledged. Any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R3: In the command byte, bit 7 = 1 selects a single-byte access at the offset in bits 6:0. Bit 7 = 0 selects a block access starting at offset 0.
- R4: A byte write (address, command, data, stop) stores the data at the addressed offset, acknowledges every byte, and shows the new value on `cfg_o`.
- R5: A byte read (address, command, repeated start, read address) returns the addressed register most significant bit first. The master then NACKs and stops.
- R6: A block write sends a byte-count byte after the command. The data bytes that follow are stored at offsets 0, 1, 2 and so on, and every byte is acknowledged.
- R7: A block read first returns a count of 10, then registers from offset 0 upward, until the master NACKs.
- R8: A stop after any complete byte ends the transaction. Bytes already acknowledged stay stored, and bytes never sent change nothing.
- R9: Offset 0 bits 2:0 read the `sel_pins_i` inputs, offset 0 bit 4 reads `cpu_stop_n_i`, offset 1 bit 7 reads `mult_sel_i`, and offset 6 always reads 0x08. Writes to these positions have no effect.
- R10: Offset 0 bit 3 reads as the AND of its stored bit and `pci_stop_n_i`.
- R11: Writes to offsets above 9 are acknowledged and ignored. Reads above offset 9 return 0x00.
- R12: The slave changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls SDA low |
| sel_pins_i | input | 3 | Frequency-select pin levels, read at offset 0 bits 2:0 |
| cpu_stop_n_i | input | 1 | CPU stop pin level, read at offset 0 bit 4 |
| pci_stop_n_i | input | 1 | PCI stop pin level, ANDed into offset 0 bit 3 |
| mult_sel_i | input | 1 | Current-multiplier pin level, read at offset 1 bit 7 |
| cfg_o | output | 80 | Stored register bits, byte i at bits 8i+7:8i |

## Verification
The assertions check on every cycle that start and stop are never seen together, that the SDA pull moves only in SCL-low time, and that the bit counter stays in range. They also check that a skipped transaction never drives SDA, that data-bit driving happens only in the read phase, and that a write beyond offset 9 leaves the register vector unchanged. The bench scenarios are the only way to show the command decode, the order of block bytes, the returned count, the pin mirrors, the AND on the stop bit, and which bytes survive an early stop. These results come from whole bus transactions seen at the pins.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } smb_phase_e;

  localparam logic [7:0] SIGNATURE_VAL = 8'h08;
  localparam int         SIGNATURE_IDX = 6;

  // Power-up contents of the stored bits.
  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a host write may change; the others are pin mirrors or constants.
  function automatic logic [7:0] reg_wmask(int idx);
    case (idx)
      0:             return 8'hE8;
      1:             return 8'h7F;
      SIGNATURE_IDX: return 8'h00;
      default:       return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sr, sda_sr;
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[TOP-1:0], scl_i};
      sda_sr <= {sda_sr[TOP-1:0], sda_i};
      scl_q  <= scl_sr[TOP];
      sda_q  <= sda_sr[TOP];
    end
  end

  assign scl_lvl   = scl_sr[TOP];
  assign sda_lvl   = sda_sr[TOP];
  assign scl_rise  =  scl_sr[TOP] & ~scl_q;
  assign scl_fall  = ~scl_sr[TOP] &  scl_q;
  assign start_det =  scl_sr[TOP] & scl_q & sda_q & ~sda_sr[TOP];
  assign stop_det  =  scl_sr[TOP] & scl_q & ~sda_q & sda_sr[TOP];

  a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int PTR_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  input  logic [2:0]            sel_pins_i,
  input  logic                  cpu_stop_n_i,
  input  logic                  pci_stop_n_i,
  input  logic                  mult_sel_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  logic [7:0] stored [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(g);
    localparam logic [7:0] WM  = reg_wmask(g);
    logic [7:0] store;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store <= DEF;
      end else if (wr_en && wr_addr == PTR_W'(g)) begin
        store <= (store & ~WM) | (wr_data & WM);
      end
    end

    assign stored[g]         = store;
    assign cfg_o[g*8 +: 8]   = store;
  end

  // Host-visible view: pin mirrors and constants overlay the stored bits.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == PTR_W'(i)) rd_data = stored[i];
    end
    if (rd_addr == PTR_W'(0)) begin
      rd_data = {stored[0][7:5], cpu_stop_n_i, stored[0][3] & pci_stop_n_i, sel_pins_i};
    end else if (rd_addr == PTR_W'(1)) begin
      rd_data = {mult_sel_i, stored[1][6:0]};
    end else if (rd_addr == PTR_W'(SIGNATURE_IDX)) begin
      rd_data = SIGNATURE_VAL;
    end
  end

  a_r11_high_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > LAST_IDX) |=> $stable(cfg_o));

endmodule

// File: rtl/smb_xact_fsm.sv
module smb_xact_fsm
  import smb_cfg_pkg::*;
#(
  parameter int         PTR_W       = 7,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         BLOCK_COUNT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  smb_phase_e       phase, nxt;
  logic [3:0]       bit_cnt;
  logic             in_ack;
  logic             blk_mode;
  logic [7:0]       shreg;
  logic [7:0]       tx;
  logic [PTR_W-1:0] ptr, ptr_next;
  logic [2:0]       bsel;

  assign ptr_next = (ptr == '1) ? ptr : ptr + 1'b1;
  assign bsel     = 3'd7 - bit_cnt[2:0];
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      nxt      <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      blk_mode <= 1'b0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
      end else if (start_det) begin
        phase    <= PH_ADDR;
        sda_pull <= 1'b0;
        in_ack   <= 1'b0;
        bit_cnt  <= '0;
      end else if (phase == PH_IDLE || phase == PH_SKIP) begin
        sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (!in_ack && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (in_ack && phase == PH_RDATA) begin
          if (sda_lvl) begin
            phase <= PH_SKIP;           // master NACK ends the read
          end else begin
            tx  <= rd_data;
            ptr <= ptr_next;
          end
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack   <= 1'b0;
          bit_cnt  <= '0;
          phase    <= nxt;
          sda_pull <= (nxt == PH_RDATA) ? ~tx[7] : 1'b0;
        end else if (bit_cnt == 4'd8) begin
          in_ack <= 1'b1;
          case (phase)
            PH_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                if (shreg[0]) begin
                  nxt <= PH_RDATA;
                  if (blk_mode) begin
                    tx  <= 8'(BLOCK_COUNT);
                  end else begin
                    tx  <= rd_data;
                    ptr <= ptr_next;
                  end
                end else begin
                  nxt <= PH_CMD;
                end
              end else begin
                phase    <= PH_SKIP;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
              end
            end
            PH_CMD: begin
              sda_pull <= 1'b1;
              blk_mode <= ~shreg[7];
              ptr      <= shreg[7] ? PTR_W'(shreg[6:0]) : '0;
              nxt      <= shreg[7] ? PH_WDATA : PH_COUNT;
            end
            PH_COUNT: begin
              sda_pull <= 1'b1;
              nxt      <= PH_WDATA;
            end
            PH_WDATA: begin
              sda_pull <= 1'b1;
              wr_en    <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= shreg;
              ptr      <= ptr_next;
              nxt      <= PH_WDATA;
            end
            default: begin              // read: free SDA for the master's ack
              sda_pull <= 1'b0;
              nxt      <= PH_RDATA;
            end
          endcase
        end else if (phase == PH_RDATA && bit_cnt != 4'd0) begin
          sda_pull <= ~tx[bsel];
        end
      end
    end
  end

  a_r12_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull != $past(sda_pull)) && !$past(stop_det) && !$past(start_det)) |-> !scl_lvl);

  a_r2_skip_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP || phase == PH_IDLE) |-> !sda_pull);

  a_r5_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);

  a_r7_data_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && !in_ack) |-> phase == PH_RDATA);

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
  parameter int         NUM_REGS    = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         BLOCK_COUNT = NUM_REGS,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [2:0]            sel_pins_i,
  input  logic                  cpu_stop_n_i,
  input  logic                  pci_stop_n_i,
  input  logic                  mult_sel_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int PTR_W = 7;

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0]       wr_data, rd_data;

  smb_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_xact_fsm #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR), .BLOCK_COUNT(BLOCK_COUNT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  smb_cfg_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_pins_i(sel_pins_i),
    .cpu_stop_n_i(cpu_stop_n_i), .pci_stop_n_i(pci_stop_n_i), .mult_sel_i(mult_sel_i),
    .cfg_o(cfg_o)
  );

endmodule

// File: tb/smb_cfg_bank_tb.sv
module smb_cfg_bank_tb;
  localparam int HALF = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_pull_o;
  logic [2:0]  sel = 3'b100;
  logic        cpu_n = 1'b1, pci_n = 1'b1, mult = 1'b0;
  logic [79:0] cfg_o;
  wire         sda_bus = m_sda & ~sda_pull_o;

  int checks = 0, failures = 0, r12_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_st [10];

  always #2 clk = ~clk;

  smb_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull_o),
    .sel_pins_i(sel), .cpu_stop_n_i(cpu_n), .pci_stop_n_i(pci_n), .mult_sel_i(mult),
    .cfg_o(cfg_o)
  );

  // R12 monitor: pull must not move while SCL is high
  logic pull_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull_o != pull_q && m_scl) r12_viol++;
    pull_q <= sda_pull_o;
  end

  function automatic logic [7:0] wmask(int i);
    case (i) 0: return 8'hE8; 1: return 8'h7F; 6: return 8'h00; default: return 8'hFF; endcase
  endfunction

  function automatic logic [7:0] view(int i);
    if (i == 0) return {exp_st[0][7:5], cpu_n, exp_st[0][3] & pci_n, sel};
    if (i == 1) return {mult, exp_st[1][6:0]};
    if (i == 6) return 8'h08;
    if (i > 9)  return 8'h00;
    return exp_st[i];
  endfunction

  task automatic model_wr(int i, logic [7:0] d);
    if (i < 10) exp_st[i] = (exp_st[i] & ~wmask(i)) | (d & wmask(i));
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_cfg(string tag);
    for (int i = 0; i < 10; i++) check(tag, 32'(cfg_o[i*8 +: 8]), 32'(exp_st[i]));
  endtask

  task automatic cw(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; cw(HALF); m_scl = 1'b1; cw(HALF); m_sda = 1'b0; cw(HALF); m_scl = 1'b0; cw(4);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; cw(HALF); m_scl = 1'b1; cw(HALF); m_sda = 1'b1; cw(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; cw(HALF); m_scl = 1'b1; cw(HALF); m_scl = 1'b0; cw(4);
    end
    m_sda = 1'b1; cw(HALF); m_scl = 1'b1; cw(HALF/2); acked = !sda_bus;
    cw(HALF/2); m_scl = 1'b0; cw(4);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cw(HALF); m_scl = 1'b1; cw(HALF/2); b[i] = sda_bus; cw(HALF/2); m_scl = 1'b0; cw(4);
    end
    m_sda = nack; cw(HALF); m_scl = 1'b1; cw(HALF); m_scl = 1'b0; cw(4); m_sda = 1'b1;
  endtask

  task automatic wr_byte(input int off, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; send_byte(8'hD2, a0); send_byte({1'b1, 7'(off)}, a1); send_byte(d, a2); bus_stop;
    ok = a0 & a1 & a2;
    model_wr(off, d);
  endtask

  task automatic rd_byte(input int off, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; send_byte(8'hD2, a0); send_byte({1'b1, 7'(off)}, a1);
    bus_start; send_byte(8'hD3, a2); recv_byte(1'b1, d); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset_defaults;
    logic [7:0] d; logic ok;
    check_cfg("R1 cfg_o default");
    for (int i = 1; i <= 5; i++) begin
      rd_byte(i, d, ok);
      check("R1 default read", 32'(d), 32'(view(i)));
    end
  endtask

  task automatic t_address_filter;
    logic a0, a1, a2;
    bus_start; send_byte(8'hA4, a0); send_byte(8'h82, a1); send_byte(8'h00, a2); bus_stop;
    check("R2 foreign address acks", {29'd0, a0, a1, a2}, 32'd0);
    check_cfg("R2 foreign write ignored");
  endtask

  task automatic t_byte_access;
    logic [7:0] d; logic ok;
    wr_byte(8, 8'h5A, ok); check("R4 byte write ack", 32'(ok), 32'd1);
    check("R4 cfg_o byte 8", 32'(cfg_o[71:64]), 32'h5A);
    rd_byte(8, d, ok); check("R5 byte read", 32'(d), 32'h5A);
    wr_byte(3, 8'h12, ok);
    rd_byte(3, d, ok); check("R3 offset decode", 32'(d), 32'h12);
    check_cfg("R3 only offset 3 and 8 moved");
  endtask

  task automatic t_block_write;
    logic a [7]; logic [7:0] dat [4] = '{8'hFF, 8'h00, 8'h3C, 8'h81};
    bus_start; send_byte(8'hD2, a[0]); send_byte(8'h00, a[1]); send_byte(8'd4, a[2]);
    for (int i = 0; i < 4; i++) begin send_byte(dat[i], a[3+i]); model_wr(i, dat[i]); end
    bus_stop;
    for (int i = 0; i < 7; i++) check("R6 block write ack", 32'(a[i]), 32'd1);
    check_cfg("R6 block write contents");
  endtask

  task automatic t_block_read;
    logic a0, a1, a2; logic [7:0] d;
    bus_start; send_byte(8'hD2, a0); send_byte(8'h00, a1);
    bus_start; send_byte(8'hD3, a2);
    recv_byte(1'b0, d); check("R7 block count", 32'(d), 32'd10);
    for (int i = 0; i < 10; i++) begin
      recv_byte(i == 9, d);
      check("R7 block byte", 32'(d), 32'(view(i)));
    end
    bus_stop;
    check("R7 block read acks", {29'd0, a0, a1, a2}, 32'd7);
  endtask

  task automatic t_partial_stop;
    logic a; logic [7:0] before2;
    before2 = exp_st[2];
    bus_start; send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd6, a);
    send_byte(8'h20, a); model_wr(0, 8'h20);
    send_byte(8'h55, a); model_wr(1, 8'h55);
    bus_stop;
    check("R8 kept byte 0", 32'(cfg_o[7:0]), 32'(exp_st[0]));
    check("R8 kept byte 1", 32'(cfg_o[15:8]), 32'(exp_st[1]));
    check("R8 unsent byte 2", 32'(cfg_o[23:16]), 32'(before2));
    bus_start; send_byte(8'hD2, a); send_byte(8'h84, a); bus_stop;
    check_cfg("R8 command then stop");
  endtask

  task automatic t_read_only;
    logic [7:0] d; logic ok;
    sel = 3'b011; cpu_n = 1'b0; mult = 1'b1;
    wr_byte(6, 8'hFF, ok); rd_byte(6, d, ok); check("R9 signature", 32'(d), 32'h08);
    wr_byte(1, 8'h00, ok); rd_byte(1, d, ok); check("R9 mult mirror", 32'(d), 32'h80);
    wr_byte(0, 8'h17, ok); rd_byte(0, d, ok);
    check("R9 sel/cpu mirror", 32'(d), 32'(view(0)));
    check("R9 cfg_o ro zero", 32'(cfg_o[7:0] & 8'h17), 32'h00);
    sel = 3'b100; cpu_n = 1'b1; mult = 1'b0;
  endtask

  task automatic t_stop_and;
    logic [7:0] d; logic ok;
    wr_byte(0, 8'h08, ok);
    pci_n = 1'b0; rd_byte(0, d, ok); check("R10 pin low", 32'(d[3]), 32'd0);
    pci_n = 1'b1; rd_byte(0, d, ok); check("R10 both high", 32'(d[3]), 32'd1);
    wr_byte(0, 8'h00, ok); rd_byte(0, d, ok); check("R10 stored low", 32'(d[3]), 32'd0);
  endtask

  task automatic t_high_offset;
    logic [7:0] d; logic ok;
    wr_byte(32, 8'hA5, ok); check("R11 high write ack", 32'(ok), 32'd1);
    check_cfg("R11 high write ignored");
    rd_byte(32, d, ok); check("R11 high read", 32'(d), 32'h00);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) exp_st[i] = 8'h00;
    exp_st[0] = 8'h08; exp_st[1] = 8'h07; exp_st[2] = 8'h7F;
    exp_st[3] = 8'hC7; exp_st[4] = 8'h3F; exp_st[5] = 8'h40;
    cw(5); rst_n = 1'b1; cw(5);
    t_reset_defaults;
    t_address_filter;
    t_byte_access;
    t_block_write;
    t_block_read;
    t_partial_stop;
    t_read_only;
    t_stop_and;
    t_high_offset;
    check("R12 pull moved with SCL high", r12_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule